// File: doc/BRIEF.md
# Nested Frame Deframer

This block sits behind a byte-wide capture buffer whose output is wrapped in two layers of framing. The outer layer is a sequence of fixed-size transport frames. Each transport frame begins with a marker byte and a count byte, and the count gives the number of payload bytes that follow. The payloads of successive transport frames, laid end to end, form a second stream of inner records. Each inner record has its own marker byte, a one-byte data count and then the data. Inner records ignore transport frame edges. One transport frame can carry several records, and one record can continue into the next transport frame.

The block removes the transport framing and walks the inner records in step. It hands each record's data bytes downstream on a valid/ready stream, marks the first and last beat, and reports the record's data count. The inner marker value can also occur inside record data, so the block never searches for it. It relies on the first payload byte after a capture restart being a record marker. A `start` level controls capture. While `start` is low, the input is stalled and all framing state is cleared. If the restart does not land on a record boundary, a sticky sync error reports it and the rest of the run is discarded.

The datapath is combinational from input to output, so an accepted data byte appears downstream in the same cycle. Only counters, state and the two error flags are registered.

Top module: `nested_deframer`

## Requirements
- R1: A transport frame is a byte 0x0D, then a count byte N, then N payload bytes. Only those payload bytes reach the record layer. Marker and count bytes are never emitted, and N = 0 yields a frame with no payload.
- R2: A record is a byte 0xA0, then a count byte L, then L data bytes. For L > 0 exactly L beats are emitted with the data in order, `out_sop` high on the first beat only, `out_eop` high on the last beat only, `out_nodata` low and `out_len` equal to L on every beat.
- R3: Records are reassembled across transport frame edges, and several records in one transport frame are each delivered intact. The transport frame size has no effect on the emitted beats.
- R4: A record with L = 0 yields exactly one beat with `out_sop`, `out_eop` and `out_nodata` all high and `out_len` = 0.
- R5: A byte in a record-marker position other than 0xA0 sets `sync_error` at the next clock edge. This includes the first payload byte after a restart. The flag stays high while `start` stays high, and no beat is emitted until the next stop and start.
- R6: A byte of value 0xA0 or 0x0D inside record data is emitted as ordinary data and does not start a record.
- R7: A transport frame whose first byte is not 0x0D sets the sticky `framing_error`. The next byte is taken as that frame's count and that many bytes are dropped unseen. Parsing then resumes with the next frame.
- R8: While `start` is low, `in_ready` and `out_valid` are low in the same cycle. One clock edge with `start` low clears both error flags and every partial frame and record count. After the next start no byte of a record cut off by the stop is emitted, and the first payload byte must be a record marker.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low. A held byte is emitted exactly once, when `out_ready` returns.
- R10: After reset with `start` low, `in_ready`, `out_valid`, `sync_error` and `framing_error` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture enable; low stops and clears framing state |
| in_data | input | 8 | Transport stream byte |
| in_valid | input | 1 | Transport byte valid |
| in_ready | output | 1 | Transport byte accepted |
| out_data | output | 8 | Record data byte |
| out_valid | output | 1 | Record beat valid |
| out_ready | input | 1 | Downstream ready |
| out_sop | output | 1 | First beat of a record |
| out_eop | output | 1 | Last beat of a record |
| out_nodata | output | 1 | Beat of a zero-length record; data not meaningful |
| out_len | output | 8 | Data count of the current record |
| sync_error | output | 1 | Sticky: record boundary lost |
| framing_error | output | 1 | Sticky: transport marker missing |

## Verification
Beats, `in_ready` and `out_valid` are combinational from the current input and state. The bench drives each byte on a falling edge and samples them one time unit later, in the same cycle the byte is offered. The error flags and the effect of `start` going low are registered, so they are due one rising edge after the byte or the stop that causes them. The bench samples them just after that edge. Beats are recorded only in cycles where they are actually taken. They are then compared in order against a list built from the records the bench itself composed.

// File: rtl/deframe_pkg.sv
package deframe_pkg;

    typedef enum logic [2:0] {
        OS_MARK,
        OS_COUNT,
        OS_PAYLOAD,
        OS_BADCOUNT,
        OS_DISCARD
    } outer_state_t;

    typedef enum logic [1:0] {
        IS_MARK,
        IS_COUNT,
        IS_DATA,
        IS_LOST
    } inner_state_t;

endpackage

// File: rtl/frame_stripper.sv
module frame_stripper
    import deframe_pkg::*;
#(
    parameter int W = 8,
    parameter logic [W-1:0] MARK = 8'h0D
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] in_data,
    input  logic         in_valid,
    output logic         in_ready,
    output logic [W-1:0] pay_data,
    output logic         pay_valid,
    input  logic         pay_ready,
    output logic         frame_err
);

    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        outer_state_t st;
        logic [W-1:0] cnt;
        logic         err;
    } oreg_t;

    oreg_t d, q;

    always_comb begin
        d         = q;
        in_ready  = 1'b0;
        pay_valid = 1'b0;
        pay_data  = in_data;
        if (!en) begin
            d.st  = OS_MARK;
            d.cnt = '0;
            d.err = 1'b0;
        end else begin
            case (q.st)
                OS_MARK: begin
                    in_ready = 1'b1;
                    if (in_valid) begin
                        if (in_data == MARK) begin
                            d.st = OS_COUNT;
                        end else begin
                            d.st  = OS_BADCOUNT;
                            d.err = 1'b1;
                        end
                    end
                end
                OS_COUNT: begin
                    in_ready = 1'b1;
                    if (in_valid) begin
                        d.cnt = in_data;
                        d.st  = (in_data == '0) ? OS_MARK : OS_PAYLOAD;
                    end
                end
                OS_PAYLOAD: begin
                    pay_valid = in_valid;
                    in_ready  = pay_ready;
                    if (in_valid && pay_ready) begin
                        d.cnt = q.cnt - ONE;
                        if (q.cnt == ONE) d.st = OS_MARK;
                    end
                end
                OS_BADCOUNT: begin
                    in_ready = 1'b1;
                    if (in_valid) begin
                        d.cnt = in_data;
                        d.st  = (in_data == '0) ? OS_MARK : OS_DISCARD;
                    end
                end
                default: begin
                    in_ready = 1'b1;
                    if (in_valid) begin
                        d.cnt = q.cnt - ONE;
                        if (q.cnt == ONE) d.st = OS_MARK;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st  <= OS_MARK;
            q.cnt <= '0;
            q.err <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign frame_err = q.err;

    // R7: framing error stays set while capture stays enabled
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (q.err && en) |=> q.err);

    // R8: a cycle with capture disabled leaves the outer layer at a clean boundary
    a_r8_outer_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (q.st == OS_MARK && q.cnt == '0 && !q.err));

    // R1: payload is only offered inside a counted frame
    a_r1_payload_only: assert property (@(posedge clk) disable iff (!rst_n)
        pay_valid |-> (q.cnt != '0));

endmodule

// File: rtl/record_parser.sv
module record_parser
    import deframe_pkg::*;
#(
    parameter int W = 8,
    parameter logic [W-1:0] MARK = 8'hA0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] pay_data,
    input  logic         pay_valid,
    output logic         pay_ready,
    output logic [W-1:0] out_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic         out_sop,
    output logic         out_eop,
    output logic         out_nodata,
    output logic [W-1:0] out_len,
    output logic         sync_err
);

    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        inner_state_t st;
        logic [W-1:0] len;
        logic [W-1:0] rem;
        logic         err;
    } ireg_t;

    ireg_t d, q;

    always_comb begin
        d          = q;
        pay_ready  = 1'b0;
        out_valid  = 1'b0;
        out_data   = pay_data;
        out_sop    = 1'b0;
        out_eop    = 1'b0;
        out_nodata = 1'b0;
        out_len    = q.len;
        if (!en) begin
            d.st  = IS_MARK;
            d.len = '0;
            d.rem = '0;
            d.err = 1'b0;
        end else begin
            case (q.st)
                IS_MARK: begin
                    pay_ready = 1'b1;
                    if (pay_valid) begin
                        if (pay_data == MARK) begin
                            d.st = IS_COUNT;
                        end else begin
                            d.st  = IS_LOST;
                            d.err = 1'b1;
                        end
                    end
                end
                IS_COUNT: begin
                    if (pay_data == '0) begin
                        out_valid  = pay_valid;
                        out_sop    = 1'b1;
                        out_eop    = 1'b1;
                        out_nodata = 1'b1;
                        out_len    = '0;
                        pay_ready  = out_ready;
                        if (pay_valid && out_ready) begin
                            d.len = '0;
                            d.st  = IS_MARK;
                        end
                    end else begin
                        pay_ready = 1'b1;
                        if (pay_valid) begin
                            d.len = pay_data;
                            d.rem = pay_data;
                            d.st  = IS_DATA;
                        end
                    end
                end
                IS_DATA: begin
                    out_valid = pay_valid;
                    pay_ready = out_ready;
                    out_sop   = (q.rem == q.len);
                    out_eop   = (q.rem == ONE);
                    if (pay_valid && out_ready) begin
                        d.rem = q.rem - ONE;
                        if (q.rem == ONE) d.st = IS_MARK;
                    end
                end
                default: begin
                    pay_ready = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st  <= IS_MARK;
            q.len <= '0;
            q.rem <= '0;
            q.err <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign sync_err = q.err;

    // R5: sync error is sticky while capture runs
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (q.err && en) |=> q.err);

    // R5: nothing is emitted once sync is lost
    a_r5_silent: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |-> !out_valid);

    // R4: a zero-length beat is a complete one-beat record
    a_r4_nodata: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_nodata) |-> (out_sop && out_eop && out_len == '0));

    // R2: a data beat always belongs to a record with a non-zero count
    a_r2_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_nodata) |-> (out_len != '0));

    // R8: one disabled cycle clears the sync error
    a_r8_inner_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !q.err);

endmodule

// File: rtl/nested_deframer.sv
module nested_deframer #(
    parameter int W = 8,
    parameter logic [W-1:0] OUTER_MARK = 8'h0D,
    parameter logic [W-1:0] INNER_MARK = 8'hA0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] in_data,
    input  logic         in_valid,
    output logic         in_ready,
    output logic [W-1:0] out_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic         out_sop,
    output logic         out_eop,
    output logic         out_nodata,
    output logic [W-1:0] out_len,
    output logic         sync_error,
    output logic         framing_error
);

    logic [W-1:0] pay_data;
    logic         pay_valid;
    logic         pay_ready;

    frame_stripper #(.W(W), .MARK(OUTER_MARK)) u_strip (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (start),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .pay_data  (pay_data),
        .pay_valid (pay_valid),
        .pay_ready (pay_ready),
        .frame_err (framing_error)
    );

    record_parser #(.W(W), .MARK(INNER_MARK)) u_parse (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (start),
        .pay_data   (pay_data),
        .pay_valid  (pay_valid),
        .pay_ready  (pay_ready),
        .out_data   (out_data),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_sop    (out_sop),
        .out_eop    (out_eop),
        .out_nodata (out_nodata),
        .out_len    (out_len),
        .sync_err   (sync_error)
    );

    // R9: a stalled downstream stalls the input
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R8: stopped capture neither accepts nor emits
    a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !start |-> (!in_ready && !out_valid));

    // R9: a held beat keeps its data until taken
    a_r9_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && start && $stable(in_data) && in_valid) |=>
        (!start || !in_valid || !$stable(in_data) || out_valid));

endmodule

// File: tb/nested_deframer_test.sv
module nested_deframer_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 50000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] out_data;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic       out_sop;
    logic       out_eop;
    logic       out_nodata;
    logic [7:0] out_len;
    logic       sync_error;
    logic       framing_error;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    logic [7:0] istr[$];
    logic [7:0] tx[$];
    int e_data[$], e_sop[$], e_eop[$], e_nd[$], e_len[$];
    int c_data[$], c_sop[$], c_eop[$], c_nd[$], c_len[$];

    nested_deframer uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .in_data       (in_data),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .out_data      (out_data),
        .out_valid     (out_valid),
        .out_ready     (out_ready),
        .out_sop       (out_sop),
        .out_eop       (out_eop),
        .out_nodata    (out_nodata),
        .out_len       (out_len),
        .sync_error    (sync_error),
        .framing_error (framing_error)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic clear_all();
        istr.delete(); tx.delete();
        e_data.delete(); e_sop.delete(); e_eop.delete(); e_nd.delete(); e_len.delete();
        c_data.delete(); c_sop.delete(); c_eop.delete(); c_nd.delete(); c_len.delete();
    endtask

    function automatic logic [7:0] pat(input int i, input int seed);
        if (i == 0) return 8'hA0;
        if (i == 1) return 8'h0D;
        return 8'((seed + i * 37) & 8'hFF);
    endfunction

    // compose one record into the inner stream and the expected beats
    task automatic add_rec(input int len, input int seed);
        istr.push_back(8'hA0);
        istr.push_back(8'(len));
        if (len == 0) begin
            e_data.push_back(0); e_sop.push_back(1); e_eop.push_back(1);
            e_nd.push_back(1); e_len.push_back(0);
        end
        for (int i = 0; i < len; i++) begin
            logic [7:0] b;
            b = pat(i, seed);
            istr.push_back(b);
            e_data.push_back(int'(b)); e_sop.push_back(i == 0 ? 1 : 0);
            e_eop.push_back(i == len - 1 ? 1 : 0); e_nd.push_back(0); e_len.push_back(len);
        end
    endtask

    // cut the inner stream into transport frames
    task automatic pack(input int flen);
        while (istr.size() > 0) begin
            int n;
            n = (istr.size() < flen) ? istr.size() : flen;
            tx.push_back(8'h0D);
            tx.push_back(8'(n));
            for (int i = 0; i < n; i++) tx.push_back(istr.pop_front());
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        in_data = b;
        in_valid = 1'b1;
        forever begin
            #1;
            if (out_valid && out_ready) begin
                c_data.push_back(int'(out_data)); c_sop.push_back(int'(out_sop));
                c_eop.push_back(int'(out_eop)); c_nd.push_back(int'(out_nodata));
                c_len.push_back(int'(out_len));
            end
            if (in_ready) break;
            @(negedge clk);
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic send_tx();
        while (tx.size() > 0) send_byte(tx.pop_front());
    endtask

    task automatic compare(input string req);
        chk(c_data.size() == e_data.size(), {req, " beat count"}, c_data.size(), e_data.size());
        for (int i = 0; i < e_data.size() && i < c_data.size(); i++) begin
            if (e_nd[i] == 0) chk(c_data[i] == e_data[i], {req, " data"}, c_data[i], e_data[i]);
            chk(c_sop[i] == e_sop[i], {req, " sop"}, c_sop[i], e_sop[i]);
            chk(c_eop[i] == e_eop[i], {req, " eop"}, c_eop[i], e_eop[i]);
            chk(c_nd[i] == e_nd[i], {req, " nodata"}, c_nd[i], e_nd[i]);
            chk(c_len[i] == e_len[i], {req, " len"}, c_len[i], e_len[i]);
        end
        clear_all();
    endtask

    task automatic restart();
        @(negedge clk);
        start = 1'b0;
        #1;
        chk(!in_ready, "R8 in_ready low while stopped", in_ready, 0);
        chk(!out_valid, "R8 out_valid low while stopped", out_valid, 0);
        @(posedge clk);
        #1;
        chk(!sync_error, "R8 sync_error cleared", sync_error, 0);
        chk(!framing_error, "R8 framing_error cleared", framing_error, 0);
        @(negedge clk);
        start = 1'b1;
    endtask

    task automatic t_reset();
        @(negedge clk);
        #1;
        chk(!in_ready, "R10 in_ready", in_ready, 0);
        chk(!out_valid, "R10 out_valid", out_valid, 0);
        chk(!sync_error, "R10 sync_error", sync_error, 0);
        chk(!framing_error, "R10 framing_error", framing_error, 0);
    endtask

    task automatic t_basic();
        restart();
        add_rec(3, 5);
        add_rec(5, 11);
        pack(16);
        send_tx();
        compare("R1 R2 two records in one frame");
    endtask

    task automatic t_span();
        restart();
        add_rec(7, 3);
        add_rec(1, 9);
        add_rec(10, 21);
        pack(4);
        tx.push_back(8'h0D);
        tx.push_back(8'h00);
        send_tx();
        compare("R3 R6 records spanning frames");
        chk(!sync_error, "R6 no sync loss on 0xA0 data", sync_error, 0);
    endtask

    task automatic t_zero();
        restart();
        add_rec(2, 40);
        add_rec(0, 0);
        add_rec(3, 50);
        pack(5);
        send_tx();
        compare("R4 zero-length record");
    endtask

    task automatic t_stall();
        logic [7:0] held;
        restart();
        add_rec(3, 60);
        pack(8);
        for (int i = 0; i < 4; i++) send_byte(tx.pop_front());
        held = tx[0];
        @(negedge clk);
        out_ready = 1'b0;
        in_data = held;
        in_valid = 1'b1;
        for (int k = 0; k < 3; k++) begin
            #1;
            chk(!in_ready, "R9 in_ready low under stall", in_ready, 0);
            chk(out_valid, "R9 beat held", out_valid, 1);
            @(negedge clk);
        end
        in_valid = 1'b0;
        out_ready = 1'b1;
        send_tx();
        compare("R9 no loss after stall");
    endtask

    task automatic t_sync();
        restart();
        tx.push_back(8'h0D); tx.push_back(8'd4);
        tx.push_back(8'h55); tx.push_back(8'hA0); tx.push_back(8'd2); tx.push_back(8'h11);
        send_byte(tx.pop_front());
        send_byte(tx.pop_front());
        send_byte(tx.pop_front());
        chk(sync_error, "R5 sync_error after bad first byte", sync_error, 1);
        send_tx();
        tx.push_back(8'h0D); tx.push_back(8'd3);
        tx.push_back(8'hA0); tx.push_back(8'd1); tx.push_back(8'h22);
        send_tx();
        chk(sync_error, "R5 sync_error sticky", sync_error, 1);
        chk(c_data.size() == 0, "R5 no beats after sync loss", c_data.size(), 0);
        clear_all();
        restart();
        add_rec(4, 70);
        pack(6);
        send_tx();
        compare("R5 recovery after restart");
    endtask

    task automatic t_framing();
        restart();
        tx.push_back(8'h33); tx.push_back(8'd3);
        tx.push_back(8'hA0); tx.push_back(8'd1); tx.push_back(8'h44);
        add_rec(1, 80);
        pack(3);
        send_tx();
        chk(framing_error, "R7 framing_error set", framing_error, 1);
        chk(!sync_error, "R7 bad frame did not reach record layer", sync_error, 0);
        compare("R7 bad frame dropped");
    endtask

    task automatic t_cut();
        restart();
        add_rec(6, 90);
        pack(4);
        for (int i = 0; i < 6; i++) send_byte(tx.pop_front());
        chk(c_data.size() == 2, "R8 partial beats before stop", c_data.size(), 2);
        clear_all();
        restart();
        add_rec(2, 100);
        pack(8);
        send_tx();
        compare("R8 nothing of the cut record after restart");
        chk(!sync_error, "R8 clean boundary after restart", sync_error, 0);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_span();
        t_zero();
        t_stall();
        t_sync();
        t_framing();
        t_cut();
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < WATCHDOG_CYCLES) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        end
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule